// File: doc/BRIEF.md
# Packed Dual-Lane 16-bit Integer ALU

This execution unit treats each of its three 32-bit operands as a pair of independent 16-bit lanes. One opcode selects the operation, and the unit applies it to the low lane and to the high lane separately. Nothing passes between the lanes: no carry, no borrow and no shifted-out bit. The unit covers wrapping add and subtract, low-half multiply, multiply-add, three kinds of shift, and minimum and maximum with either a signed or an unsigned comparison.

Shifts take their operands in reversed order. The first operand gives each lane's shift count and the second operand gives the value to shift. Opcodes come from a fixed 10-bit map. An opcode outside that map returns zero and raises a flag. The output goes through a register by default, so a result appears one clock after its inputs. The unit has no handshake: it accepts a new operation on every clock.

Top module: `pk16_alu`

## Requirements
- R1: Lane k of the result (bits 16k+15..16k) depends only on lane k of each operand. No carry, borrow or shifted bit crosses from one lane to the other.
- R2: Opcodes 0x382 and 0x38A add, and opcodes 0x383 and 0x38B subtract (first operand minus second). Each wraps modulo 2^16 per lane.
- R3: Opcode 0x381 returns the low 16 bits of each lane's 32-bit product of the first and second operands.
- R4: Opcodes 0x380 and 0x389 return (a*b + c) mod 2^16 per lane, where a, b and c are the first, second and third operands.
- R5: In every shift, the first operand's lane supplies the count and the second operand's lane supplies the value. Only the count's low 4 bits are used, so counts run from 0 to 15.
- R6: Opcode 0x384 shifts left and opcode 0x385 shifts right. Both fill vacated bits with zeros.
- R7: Opcode 0x386 shifts right and fills vacated bits with copies of the lane's bit 15.
- R8: Opcode 0x387 returns the larger and opcode 0x388 the smaller of the first two operands' lanes, compared as two's-complement values.
- R9: Opcode 0x38C returns the larger and opcode 0x38D the smaller of the first two operands' lanes, compared as unsigned values.
- R10: Any opcode not listed in R2 to R9 returns a result of zero with the illegal flag at 1. Every listed opcode gives an illegal flag of 0.
- R11: With the output register enabled (the default), result and flag appear one clock after their inputs. A synchronous reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 10 | Operation select |
| src_a | input | 32 | First operand; shift counts for shifts |
| src_b | input | 32 | Second operand; value shifted for shifts |
| src_c | input | 32 | Addend for multiply-add |
| result | output | 32 | Two 16-bit lane results |
| illegal | output | 1 | Opcode not in the map |

## Verification
The bench runs every opcode over a grid of lane values that includes 0, 1, 0x7FFF, 0x8000 and 0xFFFF. The high lane always gets a different operand pair from the low lane, so a swapped or shared lane computation shows up as a wrong lane. If the lanes leaked a carry, 0xFFFF+1 in the low lane would change the high lane. Shift counts above 15 catch a design that uses more than 4 count bits or takes the operands in normal order. Values with bit 15 set expose an arithmetic shift that fills with zeros and a signed/unsigned mix-up in min/max. The bench also sweeps all 1024 opcodes and compares the illegal flag and the zero result with the map.

// File: rtl/pk16_alu_pkg.sv
package pk16_alu_pkg;
  localparam int OPC_W = 10;

  localparam logic [OPC_W-1:0] OPC_MAD_S = 10'h380;
  localparam logic [OPC_W-1:0] OPC_MUL_L = 10'h381;
  localparam logic [OPC_W-1:0] OPC_ADD_S = 10'h382;
  localparam logic [OPC_W-1:0] OPC_SUB_S = 10'h383;
  localparam logic [OPC_W-1:0] OPC_SHL   = 10'h384;
  localparam logic [OPC_W-1:0] OPC_SHR   = 10'h385;
  localparam logic [OPC_W-1:0] OPC_SAR   = 10'h386;
  localparam logic [OPC_W-1:0] OPC_MAX_S = 10'h387;
  localparam logic [OPC_W-1:0] OPC_MIN_S = 10'h388;
  localparam logic [OPC_W-1:0] OPC_MAD_U = 10'h389;
  localparam logic [OPC_W-1:0] OPC_ADD_U = 10'h38A;
  localparam logic [OPC_W-1:0] OPC_SUB_U = 10'h38B;
  localparam logic [OPC_W-1:0] OPC_MAX_U = 10'h38C;
  localparam logic [OPC_W-1:0] OPC_MIN_U = 10'h38D;

  typedef enum logic [3:0] {
    K_NONE, K_MAD, K_MUL, K_ADD, K_SUB, K_SHL, K_SHR, K_SAR,
    K_MAXS, K_MINS, K_MAXU, K_MINU
  } lane_kind_e;
endpackage

// File: rtl/pk16_op_decode.sv
module pk16_op_decode
  import pk16_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output lane_kind_e       kind,
  output logic             bad_op
);
  always_comb begin
    kind = K_NONE;
    unique case (opcode)
      OPC_MAD_S, OPC_MAD_U: kind = K_MAD;
      OPC_MUL_L:            kind = K_MUL;
      OPC_ADD_S, OPC_ADD_U: kind = K_ADD;
      OPC_SUB_S, OPC_SUB_U: kind = K_SUB;
      OPC_SHL:              kind = K_SHL;
      OPC_SHR:              kind = K_SHR;
      OPC_SAR:              kind = K_SAR;
      OPC_MAX_S:            kind = K_MAXS;
      OPC_MIN_S:            kind = K_MINS;
      OPC_MAX_U:            kind = K_MAXU;
      OPC_MIN_U:            kind = K_MINU;
      default:              kind = K_NONE;
    endcase
    bad_op = (kind == K_NONE);
  end
endmodule

// File: rtl/pk16_lane.sv
module pk16_lane
  import pk16_alu_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  lane_kind_e        kind,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [LANE_W-1:0] c,
  output logic [LANE_W-1:0] y
);
  localparam int SH_W = $clog2(LANE_W);

  logic [2*LANE_W-1:0] prod;
  logic [SH_W-1:0]     cnt;
  logic                lt_s, lt_u;

  assign prod = a * b;
  assign cnt  = a[SH_W-1:0];
  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;

  always_comb begin
    unique case (kind)
      K_MAD:   y = prod[LANE_W-1:0] + c;
      K_MUL:   y = prod[LANE_W-1:0];
      K_ADD:   y = a + b;
      K_SUB:   y = a - b;
      K_SHL:   y = b << cnt;
      K_SHR:   y = b >> cnt;
      K_SAR:   y = $unsigned($signed(b) >>> cnt);
      K_MAXS:  y = lt_s ? b : a;
      K_MINS:  y = lt_s ? a : b;
      K_MAXU:  y = lt_u ? b : a;
      K_MINU:  y = lt_u ? a : b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/pk16_alu.sv
module pk16_alu
  import pk16_alu_pkg::*;
#(
  parameter int LANE_W  = 16,
  parameter int LANES   = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [9:0]              opcode,
  input  logic [LANES*LANE_W-1:0] src_a,
  input  logic [LANES*LANE_W-1:0] src_b,
  input  logic [LANES*LANE_W-1:0] src_c,
  output logic [LANES*LANE_W-1:0] result,
  output logic                    illegal
);
  localparam int DW   = LANES * LANE_W;
  localparam int SH_W = $clog2(LANE_W);

  lane_kind_e    kind;
  logic          bad_op;
  logic [DW-1:0] comb_y;

  pk16_op_decode u_dec (
    .opcode (opcode),
    .kind   (kind),
    .bad_op (bad_op)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb, ly;
    assign la = src_a[g*LANE_W +: LANE_W];
    assign lb = src_b[g*LANE_W +: LANE_W];

    pk16_lane #(.LANE_W(LANE_W)) u_lane (
      .kind (kind),
      .a    (la),
      .b    (lb),
      .c    (src_c[g*LANE_W +: LANE_W]),
      .y    (ly)
    );
    assign comb_y[g*LANE_W +: LANE_W] = ly;

    // R5
    shift_zero_chk: assert property (@(posedge clk) disable iff (rst)
      ((kind == K_SHL || kind == K_SHR || kind == K_SAR) && la[SH_W-1:0] == '0)
        |-> ly == lb);
    // R8
    max_signed_chk: assert property (@(posedge clk) disable iff (rst)
      (kind == K_MAXS) |-> ($signed(ly) >= $signed(la) && $signed(ly) >= $signed(lb)));
    // R9
    min_unsigned_chk: assert property (@(posedge clk) disable iff (rst)
      (kind == K_MINU) |-> (ly <= la && ly <= lb));
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        result  <= '0;
        illegal <= 1'b0;
      end else begin
        result  <= comb_y;
        illegal <= bad_op;
      end
    end

    // R11
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (result == '0 && !illegal));
    // R11
    latency_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (opcode == 10'h382) |=> !illegal);
  end else begin : g_comb
    assign result  = comb_y;
    assign illegal = bad_op;
  end

  // R10
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> result == '0);
endmodule

// File: tb/pk16_alu_bench.sv
module pk16_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  opcode = '0;
  logic [31:0] src_a = '0, src_b = '0, src_c = '0;
  logic [31:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pk16_alu u_pk16_alu (
    .clk(clk), .rst(rst), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .result(result), .illegal(illegal)
  );

  function automatic int sx(int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  function automatic bit known_op(int op);
    return op >= 'h380 && op <= 'h38D;
  endfunction

  function automatic int lane_ref(int op, int a, int b, int c);
    longint p;
    int n;
    n = a % 16;
    p = longint'(a) * longint'(b);
    case (op)
      'h380, 'h389: return int'((p + c) % 65536);
      'h381: return int'(p % 65536);
      'h382, 'h38A: return (a + b) % 65536;
      'h383, 'h38B: return (a - b + 65536) % 65536;
      'h384: return (b << n) % 65536;
      'h385: return b >> n;
      'h386: return (sx(b) >>> n) & 'hFFFF;
      'h387: return (sx(a) > sx(b)) ? a : b;
      'h388: return (sx(a) < sx(b)) ? a : b;
      'h38C: return (a > b) ? a : b;
      'h38D: return (a < b) ? a : b;
      default: return 0;
    endcase
  endfunction

  function automatic string op_tag(int op);
    case (op)
      'h380, 'h389: return "R4";
      'h381: return "R3";
      'h382, 'h383, 'h38A, 'h38B: return "R2";
      'h384, 'h385: return "R6/R5";
      'h386: return "R7/R5";
      'h387, 'h388: return "R8";
      'h38C, 'h38D: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(int op, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    @(negedge clk);
    opcode = op[9:0]; src_a = a; src_b = b; src_c = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  int vals[8] = '{'h0000, 'h0001, 'h7FFF, 'h8000, 'hFFFF, 'h1234, 'h00F0, 'h0013};

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset result", result, 32'h0);
    check("R11 reset flag", {31'b0, illegal}, 32'h0);
    rst = 1'b0;

    // R1: low lane wraps, high lane must stay zero
    apply('h382, 32'h0000_FFFF, 32'h0000_0001, 32'h0);
    check("R1 no carry", result, 32'h0000_0000);
    apply('h383, 32'h0001_0000, 32'h0000_0001, 32'h0);
    check("R1 no borrow", result, 32'h0001_FFFF);
    // R5: count 0x13 uses low 4 bits -> 3
    apply('h384, 32'h0013_0013, 32'h0001_0003, 32'h0);
    check("R5 count mask", result, 32'h0008_0018);

    for (int op = 'h380; op <= 'h38D; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          int la, lb, lc, ha, hb, hc;
          logic [31:0] exp;
          la = vals[i]; lb = vals[j]; lc = vals[(i + j) % 8];
          ha = vals[j]; hb = vals[(i + 3) % 8]; hc = vals[(j + 5) % 8];
          exp = {lane_ref(op, ha, hb, hc) [15:0], lane_ref(op, la, lb, lc) [15:0]};
          apply(op, {ha[15:0], la[15:0]}, {hb[15:0], lb[15:0]}, {hc[15:0], lc[15:0]});
          check(op_tag(op), result, exp);
          check("R10 legal flag", {31'b0, illegal}, 32'h0);
        end
      end
    end

    // R10: full opcode sweep
    for (int op = 0; op < 1024; op++) begin
      apply(op, 32'hA5A5_1234, 32'h0F0F_8001, 32'h1111_2222);
      check("R10 flag", {31'b0, illegal}, {31'b0, !known_op(op)});
      if (!known_op(op)) check("R10 zero", result, 32'h0);
    end

    // R11: reset mid-stream clears outputs
    @(negedge clk);
    opcode = 10'h3FF; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R11 sync reset", {illegal, result[30:0]}, 32'h0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule